// File: doc/BRIEF.md
# UART Baud Rate Generator with Selectable Divide Equations

This block turns the UART input clock into two strobes for the serial logic. The sample tick is the oversampling strobe for the receiver. The bit tick marks each bit period for the transmitter and the receiver. A configuration word sets the rates. It holds a 16-bit main divisor A, a 4-bit extra divisor B, an extended-divide enable and a divide-by-one select. Together these pick one of three divide equations. Each equation adds an offset of two to the main divisor.

A prescale counter fires the sample tick once every A + 2 clocks. A second counter divides the sample ticks to form the bit tick. It divides by 16 in the plain oversampling mode, by B + 1 in the extended mode, and by one in the direct mode. Some settings fall below the minimum allowed for their mode. Such a setting is raised to that minimum, and the block holds a flag until the next write. Any write restarts both counters, so no shortened or stretched period reaches the outputs.

Top module: `uart_baud_gen`

## Requirements
- R1: With the extended enable at 0 (oversampling mode), the sample tick fires once every A + 2 clocks and the bit tick once every 16 × (A + 2) clocks. The bit tick only fires in a cycle where the sample tick also fires.
- R2: With the extended enable at 1 and the divide-by-one select at 0 (extended mode), the bit tick fires once every (B + 1) × (A + 2) clocks. The sample tick keeps firing every A + 2 clocks.
- R3: In extended mode, a B below 8 is raised to 8 and the clamp flag is set. A B of exactly 8 is used as written and leaves the flag clear.
- R4: With both the extended enable and the divide-by-one select at 1 (direct mode), the bit tick and the sample tick fire together once every A + 2 clocks.
- R5: In direct mode, an A below 3 is raised to 3 and the clamp flag is set.
- R6: In oversampling mode, B and the divide-by-one select have no effect on either tick, and the clamp flag stays clear.
- R7: A write (cfg_wr high for one cycle) blocks both ticks in the write cycle itself. Counting the first cycle after the write edge as cycle 0, the first sample tick comes in cycle A + 1 and the first bit tick in the last cycle of the first full bit period. This also holds when the write lands in the middle of a period.
- R8: The clamp flag shows whether the most recent write was clamped. It changes only on a write, and a valid write clears it.
- R9: After reset the settings are A = 0, B = 0 in oversampling mode, with the flag clear. Counting the cycle in which reset is released as cycle 0, the first sample tick comes in cycle 1 and the first bit tick in cycle 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | One-cycle write strobe for the divider settings |
| cfg_div_a | input | 16 | Main divisor A |
| cfg_div_b | input | 4 | Extra divisor B |
| cfg_ext_en | input | 1 | Extended-divide enable |
| cfg_one_x | input | 1 | Divide-by-one select (used only when the extended enable is 1) |
| sample_tick | output | 1 | Oversampling strobe, one clock wide |
| bit_tick | output | 1 | Bit-period strobe, one clock wide |
| clamp_flag | output | 1 | The last write was raised to a mode minimum |

## Verification
The hardest situation to reach is a write that lands partway through a bit period. The restart must then drop both the prescale phase and the bit-divider phase, and the new equation must take effect at once. The bench first lets a long oversampling-mode period run for a while. It then rewrites the settings mid-period, both to a different mode and to the same mode, and times the first ticks from the write edge. The clamp cases are reached by writing values just below and exactly at each floor, with each clamped write followed by a valid one so the flag has to clear.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  typedef enum logic [1:0] {
    UBG_M_OVS    = 2'd0,
    UBG_M_EXT    = 2'd1,
    UBG_M_DIRECT = 2'd2
  } ubg_mode_e;

  // Mode selection from the two control bits.
  function automatic ubg_mode_e ubg_decode(input logic ext_en, input logic one_x);
    if (!ext_en)     return UBG_M_OVS;
    else if (!one_x) return UBG_M_EXT;
    else             return UBG_M_DIRECT;
  endfunction

  function automatic logic ubg_below(input int unsigned v, input int unsigned floor_v);
    return v < floor_v;
  endfunction

  function automatic int unsigned ubg_raise(input int unsigned v, input int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Number of sample ticks per bit in each mode.
  function automatic int unsigned ubg_bit_len(input ubg_mode_e m, input int unsigned b,
                                              input int unsigned ovs);
    case (m)
      UBG_M_OVS: return ovs;
      UBG_M_EXT: return b + 1;
      default:   return 1;
    endcase
  endfunction

endpackage

// File: rtl/ubg_cfg.sv
module ubg_cfg
  import ubg_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 4,
  parameter int B_MIN = 8,
  parameter int A_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           ext_en,
  input  logic           one_x,
  output logic [A_W-1:0] eff_a,
  output logic [B_W-1:0] eff_b,
  output ubg_mode_e      mode,
  output logic           flag
);

  ubg_mode_e      nxt_mode;
  logic [A_W-1:0] nxt_a;
  logic [B_W-1:0] nxt_b;
  logic           nxt_flag;
  logic           b_low;
  logic           a_low;

  always_comb begin
    nxt_mode = ubg_decode(ext_en, one_x);
    b_low    = ubg_below(32'(b_in), B_MIN);
    a_low    = ubg_below(32'(a_in), A_MIN);
    nxt_a    = a_in;
    nxt_b    = b_in;
    nxt_flag = 1'b0;
    if (nxt_mode == UBG_M_EXT && b_low) begin
      nxt_b    = B_W'(ubg_raise(32'(b_in), B_MIN));
      nxt_flag = 1'b1;
    end
    if (nxt_mode == UBG_M_DIRECT && a_low) begin
      nxt_a    = A_W'(ubg_raise(32'(a_in), A_MIN));
      nxt_flag = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_a <= '0;
      eff_b <= '0;
      mode  <= UBG_M_OVS;
      flag  <= 1'b0;
    end else if (wr) begin
      eff_a <= nxt_a;
      eff_b <= nxt_b;
      mode  <= nxt_mode;
      flag  <= nxt_flag;
    end
  end

endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
  parameter int A_W = 16,
  localparam int P_W = A_W + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [A_W-1:0] eff_a,
  output logic [P_W-1:0] pcnt,
  output logic           tick
);

  logic [P_W-1:0] last_q;
  logic           hit;

  assign last_q = P_W'(eff_a) + P_W'(1);
  assign hit    = (pcnt == last_q);
  assign tick   = hit & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (hit)     pcnt <= '0;
    else              pcnt <= pcnt + P_W'(1);
  end

endmodule

// File: rtl/ubg_bitdiv.sv
module ubg_bitdiv #(
  parameter int BD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            sample_tick,
  input  logic [BD_W-1:0] len_m1,
  output logic [BD_W-1:0] bcnt,
  output logic            tick
);

  logic at_end;

  assign at_end = (bcnt == len_m1);
  assign tick   = sample_tick & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bcnt <= '0;
    else if (restart)     bcnt <= '0;
    else if (sample_tick) bcnt <= at_end ? '0 : bcnt + BD_W'(1);
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import ubg_pkg::*;
#(
  parameter int A_W   = 16,
  parameter int B_W   = 4,
  parameter int OVS   = 16,
  parameter int B_MIN = 8,
  parameter int A_MIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [A_W-1:0] cfg_div_a,
  input  logic [B_W-1:0] cfg_div_b,
  input  logic           cfg_ext_en,
  input  logic           cfg_one_x,
  output logic           sample_tick,
  output logic           bit_tick,
  output logic           clamp_flag
);

  localparam int P_W    = A_W + 1;
  localparam int BL_MAX = (OVS > (1 << B_W)) ? OVS : (1 << B_W);
  localparam int BD_W   = (BL_MAX > 2) ? $clog2(BL_MAX) : 1;

  logic [A_W-1:0]  eff_a;
  logic [B_W-1:0]  eff_b;
  ubg_mode_e       mode_q;
  logic [P_W-1:0]  pcnt;
  logic [BD_W-1:0] bcnt;
  logic [BD_W-1:0] len_m1;

  ubg_cfg #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .A_MIN(A_MIN)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .a_in   (cfg_div_a),
    .b_in   (cfg_div_b),
    .ext_en (cfg_ext_en),
    .one_x  (cfg_one_x),
    .eff_a  (eff_a),
    .eff_b  (eff_b),
    .mode   (mode_q),
    .flag   (clamp_flag)
  );

  assign len_m1 = BD_W'(ubg_bit_len(mode_q, 32'(eff_b), OVS) - 1);

  ubg_prescale #(.A_W(A_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cfg_wr),
    .eff_a   (eff_a),
    .pcnt    (pcnt),
    .tick    (sample_tick)
  );

  ubg_bitdiv #(.BD_W(BD_W)) u_bit (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (cfg_wr),
    .sample_tick (sample_tick),
    .len_m1      (len_m1),
    .bcnt        (bcnt),
    .tick        (bit_tick)
  );

endmodule

// File: rtl/ubg_chk.sv
module ubg_chk
  import ubg_pkg::*;
#(
  parameter int A_W  = 16,
  parameter int B_W  = 4,
  parameter int BD_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic            sample_tick,
  input logic            bit_tick,
  input logic            clamp_flag,
  input logic [A_W-1:0]  eff_a,
  input logic [B_W-1:0]  eff_b,
  input ubg_mode_e       mode,
  input logic [A_W:0]    pcnt,
  input logic [BD_W-1:0] bcnt
);

  AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick); // R1
  AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick); // R1
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= ({1'b0, eff_a} + 1'b1)); // R1
  AST_EXT_B_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    mode == UBG_M_EXT |-> eff_b >= B_W'(8)); // R3
  AST_DIRECT_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    mode == UBG_M_DIRECT |-> bit_tick == sample_tick); // R4
  AST_DIRECT_A_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    mode == UBG_M_DIRECT |-> eff_a >= A_W'(3)); // R5
  AST_OVS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mode == UBG_M_OVS |-> !clamp_flag); // R6
  AST_NO_TICK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (!sample_tick && !bit_tick)); // R7
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> (pcnt == '0 && bcnt == '0)); // R7
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(clamp_flag)); // R8

endmodule

bind uart_baud_gen ubg_chk #(.A_W(A_W), .B_W(B_W), .BD_W(BD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick),
  .clamp_flag  (clamp_flag),
  .eff_a       (eff_a),
  .eff_b       (eff_b),
  .mode        (mode_q),
  .pcnt        (pcnt),
  .bcnt        (bcnt)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_div_a = '0;
  logic [3:0]  cfg_div_b = '0;
  logic        cfg_ext_en = 1'b0;
  logic        cfg_one_x = 1'b0;
  logic        sample_tick, bit_tick, clamp_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uart_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div_a(cfg_div_a),
    .cfg_div_b(cfg_div_b), .cfg_ext_en(cfg_ext_en), .cfg_one_x(cfg_one_x),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .clamp_flag(clamp_flag)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [3:0]  b;
    logic        ext;
    logic        one;
    logic [15:0] sp;   // expected sample period
    logic [15:0] bp;   // expected bit period
    logic        flag;
    logic [7:0]  req;  // requirement number for the message
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{16'd0,  4'd5,  1'b0, 1'b0, 16'd2,  16'd32, 1'b0, 8'd6}, // R6 B ignored
    '{16'd3,  4'd0,  1'b0, 1'b0, 16'd5,  16'd80, 1'b0, 8'd1}, // R1
    '{16'd1,  4'd9,  1'b1, 1'b0, 16'd3,  16'd30, 1'b0, 8'd2}, // R2
    '{16'd0,  4'd3,  1'b1, 1'b0, 16'd2,  16'd18, 1'b1, 8'd3}, // R3 clamp
    '{16'd2,  4'd15, 1'b1, 1'b0, 16'd4,  16'd64, 1'b0, 8'd8}, // R8 clears
    '{16'd0,  4'd8,  1'b1, 1'b0, 16'd2,  16'd18, 1'b0, 8'd3}, // R3 boundary
    '{16'd3,  4'd0,  1'b1, 1'b1, 16'd5,  16'd5,  1'b0, 8'd4}, // R4
    '{16'd1,  4'd0,  1'b1, 1'b1, 16'd5,  16'd5,  1'b1, 8'd5}, // R5 clamp
    '{16'd10, 4'd2,  1'b1, 1'b1, 16'd12, 16'd12, 1'b0, 8'd4}, // R4
    '{16'd0,  4'd0,  1'b0, 1'b1, 16'd2,  16'd32, 1'b0, 8'd6}  // R6 one_x ignored
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Current time is just after a negedge that is cycle 0.
  task automatic measure(output int fs, output int fb, output int gap);
    int k;
    fs = -1; fb = -1; gap = -1; k = 0;
    while (k < 3000 && gap < 0) begin
      if (sample_tick && fs < 0) fs = k;
      if (bit_tick) begin
        if (fb < 0) fb = k;
        else gap = k - fb;
      end
      @(negedge clk); #1;
      k++;
    end
  endtask

  // Writes the settings; returns just after the negedge that is cycle 0.
  task automatic do_write(input logic [15:0] a, input logic [3:0] b,
                          input logic ext, input logic one);
    @(negedge clk);
    cfg_div_a = a; cfg_div_b = b; cfg_ext_en = ext; cfg_one_x = one;
    cfg_wr = 1'b1;
    #1;
    chk("R7 no sample tick in write cycle", int'(sample_tick), 0);
    chk("R7 no bit tick in write cycle", int'(bit_tick), 0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  initial begin
    #(150000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int fs, fb, gap;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset flag", int'(clamp_flag), 0);
    chk("R9 reset sample tick", int'(sample_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    measure(fs, fb, gap);
    chk("R9 first sample tick after reset", fs, 1);
    chk("R9 first bit tick after reset", fb, 31);
    chk("R9 bit period after reset", gap, 32);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      do_write(TBL[i].a, TBL[i].b, TBL[i].ext, TBL[i].one);
      chk({tag, " flag"}, int'(clamp_flag), int'(TBL[i].flag));
      measure(fs, fb, gap);
      chk({tag, " first sample (R7)"}, fs, int'(TBL[i].sp) - 1);
      chk({tag, " first bit (R7)"}, fb, int'(TBL[i].bp) - 1);
      chk({tag, " bit period"}, gap, int'(TBL[i].bp));
    end

    // R7: rewrite mid-period into a different mode
    do_write(16'd0, 4'd0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    #1;
    do_write(16'd5, 4'd0, 1'b1, 1'b1);
    measure(fs, fb, gap);
    chk("R7 mid-period switch first sample", fs, 6);
    chk("R7 mid-period switch first bit", fb, 6);
    chk("R7 mid-period switch period", gap, 7);

    // R7: rewrite the same extended setting mid-period
    do_write(16'd1, 4'd9, 1'b1, 1'b0);
    repeat (17) @(negedge clk);
    #1;
    do_write(16'd1, 4'd9, 1'b1, 1'b0);
    measure(fs, fb, gap);
    chk("R7 same-setting rewrite first bit", fb, 29);
    chk("R2 same-setting rewrite period", gap, 30);

    // R8: flag holds across running time with no write
    do_write(16'd0, 4'd1, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    #1;
    chk("R8 flag held without write", int'(clamp_flag), 1);
    do_write(16'd4, 4'd1, 1'b0, 1'b0);
    chk("R8 flag cleared by valid write", int'(clamp_flag), 0);
    measure(fs, fb, gap);
    chk("R1 sample spacing A=4", fs, 5);
    chk("R1 bit period A=4", gap, 96);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule